// File: doc/BRIEF.md
# Locked-Cycle and Map-Miss Retry Sequencer

This block sits between a CPU bus and the master port of a slower I/O bus. It classifies every CPU cycle and decides, one cycle later, whether the cycle proceeds or must be retried. A read-lock cycle is recognised by a code the CPU drives on its parity lines at address time. Such a cycle is retried until the CPU owns the I/O bus. Owning that bus is what keeps memory locked. The lock is dropped on the very next CPU cycle of any kind, so an instruction that aborts after its read-lock cannot leave memory locked.

The same retry scheme covers CPU reads of the translation-map window that miss the map cache. The block latches the address, retries the CPU, fetches the entry over the system bus and keeps that bus while DMA work is still pending. It then hands the entry to the CPU when the CPU retries with the same address. A small fixed-priority arbiter grants the I/O bus, with the CPU above every DMA requester. An owner that already holds the bus keeps it, so the CPU waits for at most one DMA transaction.

Top module: `lock_retry_ctrl`

## Requirements
- R1: During and right after reset, no response is given, no bus is requested and no grant is active.
- R2: Parity code 2'b11 marks read-lock and 2'b10 marks write-unlock. Codes 2'b00 and 2'b01 mark normal cycles. When the block is idle, a normal or write-unlock cycle outside the map window gets a response one cycle after `cyc_valid`, with `rsp_retry` low.
- R3: A read-lock while the CPU does not own the I/O bus is answered with a retry, and the block then requests the I/O bus. Every cycle arriving before mastership is granted is retried.
- R4: Once the CPU owns the I/O bus, the retried read-lock proceeds and the grant stays high. The next CPU cycle, whatever its code, proceeds, and `cpu_iob_gnt` falls in the second cycle after it.
- R5: If mastership has been granted but the first cycle to arrive is not a read-lock, that cycle is retried and mastership is released.
- R6: A map-window read (`cyc_map`=1, `cyc_write`=0, normal code) with `cyc_cache_hit`=0 is retried. `sys_req` then rises with `sys_addr` equal to the cycle address and `sys_write` low, and every cycle during the fetch is retried.
- R7: After the entry arrives, a map read to the latched address proceeds with `rsp_fill`=1 and `rsp_data` equal to the fetched word. A map-read miss to another address is retried and restarts the fetch at the new address. Any other cycle is retried.
- R8: A map-window write proceeds at once, and the block then raises `sys_req` with `sys_write` high to update the stored map.
- R9: After `sys_done`, the system bus is kept (`sys_req` high) for as long as `dma_pending` is high, for both fetches and updates.
- R10: At most one I/O bus grant is active at a time. A requesting CPU wins over every DMA requester. A current owner keeps the bus until it drops its request. Among DMA requesters, the lowest index wins.
- R11: When the block is idle, a map-window read that hits the cache proceeds with no system bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | One-cycle strobe: a CPU cycle is at address time |
| cyc_code | input | 2 | Parity-line code captured at address time |
| cyc_write | input | 1 | Cycle is a write |
| cyc_map | input | 1 | Address lies in the translation-map window |
| cyc_cache_hit | input | 1 | Map cache holds the addressed entry |
| cyc_addr | input | AW | Cycle address |
| rsp_valid | output | 1 | Response strobe, one cycle after `cyc_valid` |
| rsp_retry | output | 1 | Cycle must be retried |
| rsp_fill | output | 1 | `rsp_data` carries a fetched map entry |
| rsp_data | output | DW | Fetched map entry, zero otherwise |
| dma_req | input | NDMA | I/O bus requests from DMA devices |
| dma_gnt | output | NDMA | I/O bus grants to DMA devices |
| cpu_iob_gnt | output | 1 | CPU owns the I/O bus (memory locked) |
| sys_req | output | 1 | System bus request for map fetch or update |
| sys_write | output | 1 | Request is a map update |
| sys_addr | output | AW | Latched map address for the request |
| sys_done | input | 1 | System bus transfer finished |
| sys_rdata | input | DW | Map entry returned with `sys_done` |
| dma_pending | input | 1 | DMA work still outstanding on the system bus |

## Verification
Every response is due exactly one clock after its `cyc_valid`. Grants are due one clock after the request change that causes them, so a change of controller state shows on `cpu_iob_gnt` two clocks after the causing cycle. `sys_req`, `sys_write` and `sys_addr` follow the state that was entered at the preceding edge. The bench model updates its expected values on the same rising edge as the design and compares every output group at the falling edge that follows. Each result is therefore checked in the cycle it is due, never earlier or later.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_BUS,
    ST_LOCKED,
    ST_FETCH,
    ST_READY
  } lrc_state_e;

  typedef enum logic [2:0] {
    CL_PLAIN,
    CL_RLOCK,
    CL_WUNLOCK,
    CL_MAP_RD_HIT,
    CL_MAP_RD_MISS,
    CL_MAP_WR
  } cyc_class_e;

  localparam logic [1:0] CODE_RLOCK   = 2'b11;
  localparam logic [1:0] CODE_WUNLOCK = 2'b10;

  // Lock codes take precedence over the map window decode.
  function automatic cyc_class_e classify(input logic [1:0] code,
                                          input logic       wr,
                                          input logic       map,
                                          input logic       hit);
    if (code == CODE_RLOCK)        return CL_RLOCK;
    else if (code == CODE_WUNLOCK) return CL_WUNLOCK;
    else if (map && wr)            return CL_MAP_WR;
    else if (map && hit)           return CL_MAP_RD_HIT;
    else if (map)                  return CL_MAP_RD_MISS;
    else                           return CL_PLAIN;
  endfunction

  function automatic logic is_map_read(input cyc_class_e c);
    return (c == CL_MAP_RD_HIT) || (c == CL_MAP_RD_MISS);
  endfunction

  function automatic logic holds_iob(input lrc_state_e s);
    return (s == ST_REQ_BUS) || (s == ST_LOCKED);
  endfunction

endpackage

// File: rtl/lrc_classify.sv
module lrc_classify
  import lrc_pkg::*;
(
  input  logic [1:0] code,
  input  logic       wr,
  input  logic       map,
  input  logic       hit,
  output cyc_class_e cls
);
  always_comb cls = classify(code, wr, map, hit);
endmodule

// File: rtl/lrc_arbiter.sv
module lrc_arbiter #(
  parameter int NDMA = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic [NDMA-1:0] dma_req,
  output logic            cpu_gnt,
  output logic [NDMA-1:0] dma_gnt
);
  // Isolate the lowest set bit: lowest index has highest DMA priority.
  function automatic logic [NDMA-1:0] lowest_set(input logic [NDMA-1:0] v);
    return v & (~v + {{(NDMA-1){1'b0}}, 1'b1});
  endfunction

  logic            owner_keeps;
  logic            cpu_nxt;
  logic [NDMA-1:0] dma_nxt;

  always_comb begin
    owner_keeps = (cpu_gnt && cpu_req) || (|(dma_gnt & dma_req));
    cpu_nxt     = cpu_gnt;
    dma_nxt     = dma_gnt;
    if (!owner_keeps) begin
      cpu_nxt = cpu_req;
      dma_nxt = cpu_req ? '0 : lowest_set(dma_req);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_gnt <= 1'b0;
    else        cpu_gnt <= cpu_nxt;
  end

  for (genvar g = 0; g < NDMA; g++) begin : g_dma_gnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_gnt[g] <= 1'b0;
      else        dma_gnt[g] <= dma_nxt[g];
    end
  end
endmodule

// File: rtl/lrc_seq.sv
module lrc_seq
  import lrc_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  cyc_class_e    cls,
  input  logic [AW-1:0] cyc_addr,
  input  logic          iob_gnt,
  input  logic          sys_done,
  input  logic [DW-1:0] sys_rdata,
  input  logic          dma_pending,
  output logic          iob_req,
  output logic          sys_req,
  output logic          sys_write,
  output logic [AW-1:0] sys_addr,
  output logic          rsp_valid,
  output logic          rsp_retry,
  output logic          rsp_fill,
  output logic [DW-1:0] rsp_data,
  output lrc_state_e    state
);
  lrc_state_e    st_q, st_d;
  logic          taken_q, taken_d;
  logic          wr_q, wr_d;
  logic          done_q, done_d;
  logic [AW-1:0] lat_q, lat_d;
  logic [DW-1:0] ent_q, ent_d;
  logic          retry, fill;

  always_comb begin
    st_d    = st_q;
    taken_d = taken_q;
    wr_d    = wr_q;
    done_d  = done_q;
    lat_d   = lat_q;
    ent_d   = ent_q;
    retry   = 1'b0;
    fill    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cyc_valid) begin
          if (cls == CL_RLOCK) begin
            retry = 1'b1;
            st_d  = ST_REQ_BUS;
          end else if (cls == CL_MAP_RD_MISS) begin
            retry  = 1'b1;
            lat_d  = cyc_addr;
            wr_d   = 1'b0;
            done_d = 1'b0;
            st_d   = ST_FETCH;
          end else if (cls == CL_MAP_WR) begin
            lat_d  = cyc_addr;
            wr_d   = 1'b1;
            done_d = 1'b0;
            st_d   = ST_FETCH;
          end
        end
      end
      ST_REQ_BUS: begin
        retry = 1'b1;
        if (iob_gnt) begin
          st_d    = ST_LOCKED;
          taken_d = 1'b0;
        end
      end
      ST_LOCKED: begin
        if (cyc_valid) begin
          if (taken_q) begin
            st_d    = ST_IDLE;
            taken_d = 1'b0;
          end else if (cls == CL_RLOCK) begin
            taken_d = 1'b1;
          end else begin
            retry = 1'b1;
            st_d  = ST_IDLE;
          end
        end
      end
      ST_FETCH: begin
        retry = 1'b1;
        if (sys_done && !done_q) begin
          done_d = 1'b1;
          if (!wr_q) ent_d = sys_rdata;
        end else if (done_q && !dma_pending) begin
          st_d = wr_q ? ST_IDLE : ST_READY;
        end
      end
      ST_READY: begin
        if (cyc_valid) begin
          if (is_map_read(cls) && (cyc_addr == lat_q)) begin
            fill = 1'b1;
            st_d = ST_IDLE;
          end else if (cls == CL_MAP_RD_MISS) begin
            retry  = 1'b1;
            lat_d  = cyc_addr;
            done_d = 1'b0;
            st_d   = ST_FETCH;
          end else begin
            retry = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      taken_q   <= 1'b0;
      wr_q      <= 1'b0;
      done_q    <= 1'b0;
      lat_q     <= '0;
      ent_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_fill  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      st_q      <= st_d;
      taken_q   <= taken_d;
      wr_q      <= wr_d;
      done_q    <= done_d;
      lat_q     <= lat_d;
      ent_q     <= ent_d;
      rsp_valid <= cyc_valid;
      rsp_retry <= cyc_valid && retry;
      rsp_fill  <= cyc_valid && fill;
      rsp_data  <= (cyc_valid && fill) ? ent_q : '0;
    end
  end

  assign iob_req   = holds_iob(st_q);
  assign sys_req   = (st_q == ST_FETCH);
  assign sys_write = sys_req && wr_q;
  assign sys_addr  = sys_req ? lat_q : '0;
  assign state     = st_q;
endmodule

// File: rtl/lock_retry_ctrl.sv
module lock_retry_ctrl
  import lrc_pkg::*;
#(
  parameter int AW   = 22,
  parameter int DW   = 32,
  parameter int NDMA = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_valid,
  input  logic [1:0]      cyc_code,
  input  logic            cyc_write,
  input  logic            cyc_map,
  input  logic            cyc_cache_hit,
  input  logic [AW-1:0]   cyc_addr,
  output logic            rsp_valid,
  output logic            rsp_retry,
  output logic            rsp_fill,
  output logic [DW-1:0]   rsp_data,
  input  logic [NDMA-1:0] dma_req,
  output logic [NDMA-1:0] dma_gnt,
  output logic            cpu_iob_gnt,
  output logic            sys_req,
  output logic            sys_write,
  output logic [AW-1:0]   sys_addr,
  input  logic            sys_done,
  input  logic [DW-1:0]   sys_rdata,
  input  logic            dma_pending
);
  cyc_class_e cyc_cls;
  lrc_state_e seq_state;
  logic       iob_req;

  lrc_classify u_cls (
    .code (cyc_code),
    .wr   (cyc_write),
    .map  (cyc_map),
    .hit  (cyc_cache_hit),
    .cls  (cyc_cls)
  );

  lrc_arbiter #(.NDMA(NDMA)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_req (iob_req),
    .dma_req (dma_req),
    .cpu_gnt (cpu_iob_gnt),
    .dma_gnt (dma_gnt)
  );

  lrc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_valid   (cyc_valid),
    .cls         (cyc_cls),
    .cyc_addr    (cyc_addr),
    .iob_gnt     (cpu_iob_gnt),
    .sys_done    (sys_done),
    .sys_rdata   (sys_rdata),
    .dma_pending (dma_pending),
    .iob_req     (iob_req),
    .sys_req     (sys_req),
    .sys_write   (sys_write),
    .sys_addr    (sys_addr),
    .rsp_valid   (rsp_valid),
    .rsp_retry   (rsp_retry),
    .rsp_fill    (rsp_fill),
    .rsp_data    (rsp_data),
    .state       (seq_state)
  );
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker
  import lrc_pkg::*;
#(
  parameter int NDMA = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_valid,
  input logic [1:0]      cyc_code,
  input logic            rsp_valid,
  input logic            rsp_retry,
  input logic            rsp_fill,
  input logic [NDMA-1:0] dma_req,
  input logic [NDMA-1:0] dma_gnt,
  input logic            cpu_iob_gnt,
  input logic            iob_req,
  input logic            sys_req,
  input logic            dma_pending,
  input lrc_state_e      seq_state
);
  assert_rsp_follows_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cyc_valid));

  assert_idle_lock_retried_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == CODE_RLOCK && seq_state == ST_IDLE) |=> rsp_retry);

  assert_lock_needs_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_code == CODE_RLOCK) |=> (rsp_retry || cpu_iob_gnt));

  assert_fill_proceeds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fill |-> (rsp_valid && !rsp_retry));

  assert_sys_kept_for_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_req) |-> $past(!dma_pending));

  assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_gnt, cpu_iob_gnt}));

  assert_cpu_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iob_req && !cpu_iob_gnt && ((dma_gnt & dma_req) == '0)) |=> cpu_iob_gnt);
endmodule

bind lock_retry_ctrl lrc_checker #(.NDMA(NDMA)) u_lrc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_valid   (cyc_valid),
  .cyc_code    (cyc_code),
  .rsp_valid   (rsp_valid),
  .rsp_retry   (rsp_retry),
  .rsp_fill    (rsp_fill),
  .dma_req     (dma_req),
  .dma_gnt     (dma_gnt),
  .cpu_iob_gnt (cpu_iob_gnt),
  .iob_req     (iob_req),
  .sys_req     (sys_req),
  .dma_pending (dma_pending),
  .seq_state   (seq_state)
);

// File: tb/lock_retry_ctrl_bench.sv
module lock_retry_ctrl_bench;
  localparam int AW   = 22;
  localparam int DW   = 32;
  localparam int NDMA = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cyc_valid = 1'b0;
  logic [1:0]      cyc_code = 2'b00;
  logic            cyc_write = 1'b0;
  logic            cyc_map = 1'b0;
  logic            cyc_cache_hit = 1'b0;
  logic [AW-1:0]   cyc_addr = '0;
  logic            rsp_valid, rsp_retry, rsp_fill;
  logic [DW-1:0]   rsp_data;
  logic [NDMA-1:0] dma_req = '0;
  logic [NDMA-1:0] dma_gnt;
  logic            cpu_iob_gnt;
  logic            sys_req, sys_write;
  logic [AW-1:0]   sys_addr;
  logic            sys_done = 1'b0;
  logic [DW-1:0]   sys_rdata = '0;
  logic            dma_pending = 1'b0;

  always #5 clk = ~clk;

  lock_retry_ctrl #(.AW(AW), .DW(DW), .NDMA(NDMA)) u_lock_retry_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_code(cyc_code),
    .cyc_write(cyc_write), .cyc_map(cyc_map), .cyc_cache_hit(cyc_cache_hit),
    .cyc_addr(cyc_addr), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
    .rsp_fill(rsp_fill), .rsp_data(rsp_data), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .cpu_iob_gnt(cpu_iob_gnt), .sys_req(sys_req), .sys_write(sys_write),
    .sys_addr(sys_addr), .sys_done(sys_done), .sys_rdata(sys_rdata),
    .dma_pending(dma_pending)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_run = 1'b0;

  // Reference model: mode 0 idle, 1 waiting for bus, 2 bus held, 3 system bus work, 4 entry ready.
  int            mode, owner, prev_mode, kind, nxt_owner;
  bit            lock_used, upd_op, xfer_done, cpu_wants, owner_drops;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_entry;
  bit            e_valid, e_retry, e_fill, e_cpu, e_sreq, e_swr;
  logic [DW-1:0] e_data;
  logic [AW-1:0] e_saddr;
  logic [NDMA-1:0] e_dma;
  string         e_tag, s_tag, g_tag;

  function automatic int kind_of(logic [1:0] c, logic w, logic m, logic h);
    if (c == 2'b11) return 1;            // read-lock
    if (c == 2'b10) return 2;            // write-unlock
    if (m && w)     return 5;            // map write
    if (m && h)     return 3;            // map read hit
    if (m)          return 4;            // map read miss
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; owner = -1; lock_used = 0; upd_op = 0; xfer_done = 0;
      m_addr = '0; m_entry = '0;
      e_valid = 0; e_retry = 0; e_fill = 0; e_data = '0; e_cpu = 0; e_dma = '0;
      e_sreq = 0; e_swr = 0; e_saddr = '0;
      e_tag = "R1"; s_tag = "R1"; g_tag = "R1";
    end else begin
      cpu_wants   = (mode == 1) || (mode == 2);
      owner_drops = (owner == -1) || (owner == -2 && !cpu_wants) ||
                    (owner >= 0 && dma_req[owner & (NDMA-1)] == 1'b0);
      nxt_owner = owner;
      if (owner_drops) begin
        if (cpu_wants) nxt_owner = -2;
        else begin
          nxt_owner = -1;
          for (int k = NDMA - 1; k >= 0; k--) if (dma_req[k]) nxt_owner = k;
        end
      end
      kind = kind_of(cyc_code, cyc_write, cyc_map, cyc_cache_hit);
      e_valid = cyc_valid; e_retry = 0; e_fill = 0; e_data = '0; e_tag = "R2";
      prev_mode = mode;
      if (prev_mode == 0) begin
        if (cyc_valid && kind == 1) begin e_retry = 1; mode = 1; e_tag = "R3"; end
        else if (cyc_valid && kind == 4) begin
          e_retry = 1; m_addr = cyc_addr; upd_op = 0; xfer_done = 0; mode = 3; e_tag = "R6";
        end else if (cyc_valid && kind == 5) begin
          m_addr = cyc_addr; upd_op = 1; xfer_done = 0; mode = 3; e_tag = "R8";
        end else if (cyc_valid && kind == 3) e_tag = "R11";
      end else if (prev_mode == 1) begin
        if (cyc_valid) begin e_retry = 1; e_tag = "R3"; end
        if (owner == -2) begin mode = 2; lock_used = 0; end
      end else if (prev_mode == 2) begin
        if (cyc_valid) begin
          e_tag = "R4";
          if (lock_used) begin mode = 0; lock_used = 0; end
          else if (kind == 1) lock_used = 1;
          else begin e_retry = 1; mode = 0; e_tag = "R5"; end
        end
      end else if (prev_mode == 3) begin
        if (cyc_valid) begin e_retry = 1; e_tag = upd_op ? "R8" : "R6"; end
        if (sys_done && !xfer_done) begin
          xfer_done = 1;
          if (!upd_op) m_entry = sys_rdata;
        end else if (xfer_done && !dma_pending) mode = upd_op ? 0 : 4;
      end else begin
        if (cyc_valid) begin
          e_tag = "R7";
          if ((kind == 3 || kind == 4) && cyc_addr == m_addr) begin
            e_fill = 1; e_data = m_entry; mode = 0;
          end else if (kind == 4) begin
            e_retry = 1; m_addr = cyc_addr; xfer_done = 0; mode = 3;
          end else e_retry = 1;
        end
      end
      owner = nxt_owner;
      e_cpu = (owner == -2);
      e_dma = '0;
      if (owner >= 0) e_dma[owner & (NDMA-1)] = 1'b1;
      g_tag = "R10";
      e_sreq = (mode == 3);
      e_swr = (mode == 3) && upd_op;
      e_saddr = (mode == 3) ? m_addr : '0;
      s_tag = upd_op ? "R8" : "R9";
    end
  end

  always @(negedge clk) begin
    if (!done_run) begin
      checks++;
      if ({rsp_valid, rsp_retry, rsp_fill} !== {e_valid, e_retry, e_fill} || rsp_data !== e_data) begin
        errors++;
        $display("FAIL %s rsp v/r/f=%b%b%b data=%h expected %b%b%b data=%h",
                 e_tag, rsp_valid, rsp_retry, rsp_fill, rsp_data, e_valid, e_retry, e_fill, e_data);
      end
      checks++;
      if ({sys_req, sys_write} !== {e_sreq, e_swr} || sys_addr !== e_saddr) begin
        errors++;
        $display("FAIL %s sys req/wr=%b%b addr=%h expected %b%b addr=%h",
                 s_tag, sys_req, sys_write, sys_addr, e_sreq, e_swr, e_saddr);
      end
      checks++;
      if ({dma_gnt, cpu_iob_gnt} !== {e_dma, e_cpu}) begin
        errors++;
        $display("FAIL %s grants dma=%b cpu=%b expected dma=%b cpu=%b",
                 g_tag, dma_gnt, cpu_iob_gnt, e_dma, e_cpu);
      end
    end
  end

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [1:0] c, logic w, logic m, logic h, logic [AW-1:0] a);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_code = c; cyc_write = w; cyc_map = m; cyc_cache_hit = h; cyc_addr = a;
    @(negedge clk);
    cyc_valid = 1'b0; cyc_code = 2'b00; cyc_write = 1'b0; cyc_map = 1'b0;
    cyc_cache_hit = 1'b0; cyc_addr = '0;
  endtask

  task automatic finish_xfer(logic [DW-1:0] d);
    @(negedge clk);
    sys_done = 1'b1; sys_rdata = d;
    @(negedge clk);
    sys_done = 1'b0; sys_rdata = '0;
  endtask

  initial begin
    // R1: reset state observed by the compare block during reset
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R2: normal codes and write-unlock proceed when idle
    issue(2'b00, 1'b0, 1'b0, 1'b0, 22'h000100);
    issue(2'b01, 1'b1, 1'b0, 1'b0, 22'h000104);
    issue(2'b10, 1'b1, 1'b0, 1'b0, 22'h000108);
    // R11: map read hit proceeds with no system request
    issue(2'b00, 1'b0, 1'b1, 1'b1, 22'h003000);
    // R3 / R10: DMA owns the bus, read-lock is retried
    dma_req = 4'b0100;
    idle(2);
    issue(2'b11, 1'b0, 1'b0, 1'b0, 22'h000200);
    idle(2);
    issue(2'b11, 1'b0, 1'b0, 1'b0, 22'h000200);
    dma_req = 4'b0111;
    idle(1);
    dma_req = 4'b0011;
    idle(3);
    // R4: lock proceeds, next cycle of any code releases
    issue(2'b11, 1'b0, 1'b0, 1'b0, 22'h000200);
    idle(2);
    issue(2'b00, 1'b1, 1'b0, 1'b0, 22'h000200);
    idle(3);
    dma_req = 4'b0000;
    idle(2);
    // R5: granted, but the first cycle is not a read-lock
    issue(2'b11, 1'b0, 1'b0, 1'b0, 22'h000300);
    idle(3);
    issue(2'b01, 1'b0, 1'b0, 1'b0, 22'h000300);
    idle(2);
    issue(2'b00, 1'b0, 1'b0, 1'b0, 22'h000300);
    // R6 / R9: map miss fetch, system bus held while DMA pending
    issue(2'b00, 1'b0, 1'b1, 1'b0, 22'h001234);
    idle(1);
    issue(2'b00, 1'b0, 1'b0, 1'b0, 22'h000010);
    dma_pending = 1'b1;
    finish_xfer(32'hDEADBEEF);
    idle(3);
    dma_pending = 1'b0;
    idle(2);
    // R7: other cycle retried, mismatched miss refetches, matching read fills
    issue(2'b00, 1'b0, 1'b0, 1'b0, 22'h000020);
    issue(2'b00, 1'b0, 1'b1, 1'b0, 22'h002000);
    idle(1);
    finish_xfer(32'hCAFE0001);
    idle(3);
    issue(2'b00, 1'b0, 1'b1, 1'b1, 22'h002000);
    idle(2);
    // R8: map write proceeds, then an update request
    issue(2'b01, 1'b1, 1'b1, 1'b0, 22'h001800);
    idle(1);
    dma_pending = 1'b1;
    finish_xfer(32'h0);
    idle(2);
    dma_pending = 1'b0;
    idle(4);
    finish_run();
  end
endmodule